// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. It has no clock and no state: the product follows the operands through combinational logic. Every partial-product bit is a two-input AND of one bit from each operand. The bits are summed in a square grid of adders.

Inside the grid, no carry travels sideways along a row. Each adder sends its carry one column to the left and one row down, where the next row adds it in. Each row therefore has the depth of one adder, whatever the width. Because the second partial-product row starts with an empty carry vector, that row is built from half adders only. A last ripple row merges the sums and carries that are still pending and produces the upper half of the product. The longest path is about 2N full-adder delays.

The width is a parameter (N >= 2). The default is 8. A 4-bit instance is small enough to test exhaustively.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals the arithmetic product of `op_a` and `op_b`, using all 2N bits.
- R2: Product bit 0 equals `op_a[0] & op_b[0]`.
- R3: If either operand is zero, every product bit is zero.
- R4: If `op_b` is 1, the low N product bits equal `op_a` and the high N bits are zero.
- R5: With both operands at all ones, the product is (2^N-1)^2, which is 0xE1 for N = 4 and 0xFE01 for N = 8.
- R6: The product never exceeds (2^N-1)^2.
- R7: The output is combinational. A change on an operand shows on `prod` with no clock edge.
- R8: Multiplying by 2^k returns `op_a` shifted left by k bits, for every k from 0 to N-1.
- R9: The same structure gives correct products when N is set to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product |

## Verification
The hardest cases are long carry chains in the final merge row. In these, the carries sent down the diagonals of every row all land in the upper columns together. They show up only for operand pairs with many ones, such as all-ones times all-ones or alternating bit patterns. For the 4-bit instance, the stimulus covers all 256 operand pairs, so every diagonal carry combination is reached. The 8-bit instance gets a table that includes the all-ones pair, alternating patterns and powers of two.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;

  // sum output of a one-bit adder with three inputs
  function automatic logic add3_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // carry output of a one-bit adder with three inputs (majority)
  function automatic logic add3_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/csa_full_add.sv
module csa_full_add
  import csa_mul_pkg::*;
(
  input  logic in_x,
  input  logic in_y,
  input  logic in_z,
  output logic sum,
  output logic carry
);

  always_comb begin
    sum   = add3_sum(in_x, in_y, in_z);
    carry = add3_carry(in_x, in_y, in_z);
  end

endmodule

// File: rtl/csa_half_add.sv
module csa_half_add (
  input  logic in_x,
  input  logic in_y,
  output logic sum,
  output logic carry
);

  always_comb begin
    sum   = in_x ^ in_y;
    carry = in_x & in_y;
  end

endmodule

// File: rtl/csa_first_row.sv
// First adding row: the incoming carry vector is empty, so half adders suffice.
module csa_first_row #(
  parameter int N = 8
) (
  input  logic [N-1:0] pp_row,
  input  logic [N-1:0] sum_prev,
  output logic [N-1:0] sum_out,
  output logic [N-1:0] carry_out
);

  for (genvar j = 0; j < N; j++) begin : g_col
    csa_half_add u_ha (
      .in_x  (pp_row[j]),
      .in_y  (sum_prev[j]),
      .sum   (sum_out[j]),
      .carry (carry_out[j])
    );
  end

endmodule

// File: rtl/csa_cs_row.sv
// Carry-save row: carries leave diagonally and are never chained within the row.
module csa_cs_row #(
  parameter int N = 8
) (
  input  logic [N-1:0] pp_row,
  input  logic [N-1:0] sum_prev,
  input  logic [N-1:0] carry_prev,
  output logic [N-1:0] sum_out,
  output logic [N-1:0] carry_out
);

  for (genvar j = 0; j < N; j++) begin : g_col
    csa_full_add u_fa (
      .in_x  (pp_row[j]),
      .in_y  (sum_prev[j]),
      .in_z  (carry_prev[j]),
      .sum   (sum_out[j]),
      .carry (carry_out[j])
    );
  end

endmodule

// File: rtl/csa_ripple_merge.sv
// Final carry-propagate row. The top carry is dropped because the product fits in 2N bits.
module csa_ripple_merge #(
  parameter int N = 8
) (
  input  logic [N-1:0] add_x,
  input  logic [N-1:0] add_y,
  output logic [N-1:0] result
);

  logic [N-1:0] chain;

  assign chain[0] = 1'b0;

  for (genvar j = 0; j < N; j++) begin : g_bit
    if (j < N - 1) begin : g_mid
      csa_full_add u_fa (
        .in_x  (add_x[j]),
        .in_y  (add_y[j]),
        .in_z  (chain[j]),
        .sum   (result[j]),
        .carry (chain[j+1])
      );
    end else begin : g_top
      assign result[j] = add_x[j] ^ add_y[j] ^ chain[j];
    end
  end

endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
  parameter int N = 8
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);

  localparam int LAST = N - 1;

  // partial products: row i weights op_a by op_b[i]
  logic [N-1:0] pp [N];
  // after stage k: sum_st[k][j] has weight k+j, carry_st[k][j] has weight k+j+1
  logic [N-1:0] sum_st   [N];
  logic [N-1:0] carry_st [1:LAST];
  logic [N-1:0] sum_sh   [1:LAST];
  logic [N-1:0] low_half;
  logic [N-1:0] high_half;

  for (genvar i = 0; i < N; i++) begin : g_pp
    assign pp[i] = op_a & {N{op_b[i]}};
  end

  assign sum_st[0]   = pp[0];
  assign low_half[0] = sum_st[0][0];

  for (genvar k = 1; k < N; k++) begin : g_row
    // the previous row's sums drop one column to line up with row k
    assign sum_sh[k] = {1'b0, sum_st[k-1][N-1:1]};

    if (k == 1) begin : g_half
      csa_first_row #(.N(N)) u_row (
        .pp_row    (pp[k]),
        .sum_prev  (sum_sh[k]),
        .sum_out   (sum_st[k]),
        .carry_out (carry_st[k])
      );
    end else begin : g_full
      csa_cs_row #(.N(N)) u_row (
        .pp_row     (pp[k]),
        .sum_prev   (sum_sh[k]),
        .carry_prev (carry_st[k-1]),
        .sum_out    (sum_st[k]),
        .carry_out  (carry_st[k])
      );
    end

    assign low_half[k] = sum_st[k][0];
  end

  csa_ripple_merge #(.N(N)) u_merge (
    .add_x  ({1'b0, sum_st[LAST][N-1:1]}),
    .add_y  (carry_st[LAST]),
    .result (high_half)
  );

  assign prod = {high_half, low_half};

endmodule

// File: rtl/csa_mul_chk.sv
module csa_mul_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod
);

  localparam logic [2*N-1:0] ONES_EXT = {{N{1'b0}}, {N{1'b1}}};
  localparam logic [2*N-1:0] MAX_PROD = ONES_EXT * ONES_EXT;
  localparam logic [N-1:0]   ONE_N    = {{(N-1){1'b0}}, 1'b1};

  logic [2*N-1:0] ref_prod;
  logic           known;

  always_comb begin
    ref_prod = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
    known    = !$isunknown({op_a, op_b, prod});
  end

  always_comb begin
    if (known) begin
      // R1
      product_value_chk: assert (prod == ref_prod);
      // R2
      lsb_and_chk: assert (prod[0] == (op_a[0] & op_b[0]));
      // R3
      zero_operand_chk: assert (!((op_a == '0) || (op_b == '0)) || (prod == '0));
      // R4
      unit_multiplier_chk: assert ((op_b != ONE_N) || (prod == {{N{1'b0}}, op_a}));
      // R6
      no_overflow_chk: assert (prod <= MAX_PROD);
    end
  end

endmodule

bind csa_array_mult csa_mul_chk #(.N(N)) u_chk (
  .op_a (op_a),
  .op_b (op_b),
  .prod (prod)
);

// File: tb/sim_csa_array_mult.sv
module sim_csa_array_mult;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NL = 8;
  localparam int NVEC = 10;

  // {op_a, op_b, product} for the 8-bit instance
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd255, 8'd255, 16'd65025},
    {8'd0,   8'd200, 16'd0},
    {8'd1,   8'd173, 16'd173},
    {8'd128, 8'd128, 16'd16384},
    {8'd170, 8'd85,  16'd14450},
    {8'd37,  8'd201, 16'd7437},
    {8'd255, 8'd1,   16'd255},
    {8'd99,  8'd99,  16'd9801},
    {8'd240, 8'd15,  16'd3600},
    {8'd200, 8'd123, 16'd24600}
  };

  logic clk;
  logic [NS-1:0]   a4, b4;
  logic [2*NS-1:0] p4;
  logic [NL-1:0]   a8, b8;
  logic [2*NL-1:0] p8;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  csa_array_mult #(.N(NS)) u0 (.op_a(a4), .op_b(b4), .prod(p4));
  csa_array_mult #(.N(NL)) u1 (.op_a(a8), .op_b(b8), .prod(p8));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    @(negedge clk);
    // R3 idle state with zero operands
    check("R3", 16'(p4), 16'd0);
    check("R3", p8, 16'd0);

    // R9 table walk on the 8-bit instance
    for (int v = 0; v < NVEC; v++) begin
      @(posedge clk);
      a8 = VEC[v][31:24];
      b8 = VEC[v][23:16];
      @(negedge clk);
      check("R9", p8, VEC[v][15:0]);
    end

    // R1 R2 R3 R4 R6 exhaustive on the 4-bit instance
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(posedge clk);
        a4 = NS'(i);
        b4 = NS'(j);
        @(negedge clk);
        check("R1", 16'(p4), 16'(i * j));
        check("R2", 16'(p4[0]), 16'(i & j & 1));
        if (i == 0 || j == 0) check("R3", 16'(p4), 16'd0);
        if (j == 1) check("R4", 16'(p4), 16'(i));
        check("R6", 16'(p4 <= 8'd225), 16'd1);
      end
    end

    // R5 all ones on both widths
    @(posedge clk);
    a4 = 4'hF; b4 = 4'hF; a8 = 8'hFF; b8 = 8'hFF;
    @(negedge clk);
    check("R5", 16'(p4), 16'h00E1);
    check("R5", p8, 16'hFE01);

    // R8 powers of two on the 8-bit instance
    for (int k = 0; k < NL; k++) begin
      @(posedge clk);
      a8 = 8'd173;
      b8 = NL'(1 << k);
      @(negedge clk);
      check("R8", p8, 16'(173 << k));
    end

    // R7 operand change between clock edges shows without an edge
    @(negedge clk);
    a8 = 8'd12; b8 = 8'd11;
    #1;
    check("R7", p8, 16'd132);
    a8 = 8'd250;
    #1;
    check("R7", p8, 16'd2750);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule